// File: doc/BRIEF.md
# DMA Thread Precise Abort Detector

This block sits beside the instruction issue point of a multi-thread DMA engine. Each thread is either one of the channel threads or the single manager thread. Every issued instruction arrives as pre-decoded information: the issuing thread, the instruction's address, an operation class, an index operand, and flags for a secure bus access, an undefined encoding and a fetch error. The block also reads the security state of each thread and the per-resource security configuration. From these it decides in one step whether the instruction may run or must abort.

When an instruction faults, the block suppresses it and issues a no-operation in its place. It returns the faulting address so the thread's program counter can be rewound. It latches a cause code for that thread and raises a single abort line that feeds both the processors and the programmable logic. The faulting thread then stays frozen, and any further instructions it issues are dropped, until software kills it.

Top module: `abt_precise_detector`

## Requirements
- R1: One cycle after a faulting instruction is accepted, `pc_ld` is 1, `pc_ld_addr` equals that instruction's `ins_pc` and `pc_ld_tid` equals its `ins_tid`. Otherwise `pc_ld` is 0.
- R2: An accepted instruction with no fault gives `ex_vld`=1 and `ex_nop`=0 one cycle later. A faulting one gives `ex_vld`=0 and `ex_nop`=1, so it is replaced by a no-operation. Operation classes are 0 plain, 1 channel-control write, 2 event, 3 peripheral request, 4 go, and 5 to 7 undefined.
- R3: A class-1 instruction with `ins_sec_txn`=1 issued by a non-secure thread (`thr_ns` bit = 1) faults with cause 1.
- R4: A class-2 instruction from a non-secure thread faults with cause 2 when `ev_ns_cfg[ins_arg]` is 0, meaning the event is secure.
- R5: A class-3 instruction from a non-secure thread faults with cause 3 when `per_ns_cfg[ins_arg]` is 0.
- R6: A class-4 instruction from a non-secure issuer faults with cause 4 when `ch_ns_cfg[ins_arg]` is 0, meaning the target channel is secure.
- R7: `ins_fetch_err`=1 faults with cause 5 and overrides every other cause.
- R8: Cause 6 is raised by any of the following, and it outranks the security causes:
  - `ins_bad`=1;
  - an operation class of 5 to 7;
  - an index at or above the configured count of events, peripheral interfaces or channels for classes 2, 3 and 4.
- R9: A faulting thread keeps its `flt_vec` bit set and its cause in `cause_bus[3t+2:3t]` until `kill_vld` names it. Its later instructions are dropped, with no `ex_vld`, `ex_nop` or `pc_ld`. A kill of a thread that is not faulting has no effect. A fault set in the same cycle as a kill of that thread wins.
- R10: After reset, every output is 0. `abort_o` is 1 exactly while at least one `flt_vec` bit is set.
- R11: An instruction whose `ins_tid` is at or above the thread count (channels are 0 to NCH-1, the manager is NCH) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_vld | input | 1 | An instruction is issued this cycle |
| ins_tid | input | TIDW | Issuing thread |
| ins_pc | input | AW | Address of the issued instruction |
| ins_op | input | 3 | Operation class |
| ins_arg | input | ARGW | Event, peripheral or channel index |
| ins_sec_txn | input | 1 | Channel-control write uses a secure bus access |
| ins_bad | input | 1 | Undefined encoding or invalid operand |
| ins_fetch_err | input | 1 | Error response on the fetch of this instruction |
| thr_ns | input | NTH | Per-thread non-secure state |
| ev_ns_cfg | input | NEV | Per-event non-secure flag |
| per_ns_cfg | input | NPER | Per-peripheral-interface non-secure flag |
| ch_ns_cfg | input | NCH | Per-channel non-secure flag |
| kill_vld | input | 1 | Kill request |
| kill_tid | input | TIDW | Thread to kill |
| ex_vld | output | 1 | Instruction executes normally |
| ex_nop | output | 1 | Instruction replaced by a no-operation |
| pc_ld | output | 1 | Rewind program counter |
| pc_ld_tid | output | TIDW | Thread whose counter is rewound |
| pc_ld_addr | output | AW | Faulting instruction address |
| flt_vec | output | NTH | Per-thread faulting state |
| cause_bus | output | 3*NTH | Per-thread cause codes, 3 bits per thread |
| abort_o | output | 1 | Abort to processors and programmable logic |

## Verification
The bench sweeps every thread, all eight operation classes, all index values, both thread security states and three error-flag patterns, under two complementary security configurations. This sweep separates each security cause from its secure-thread and non-secure-resource twins, and it exposes out-of-range indices and the priority order. Each fault is followed by a dropped instruction from the same thread and then a kill, which confirms that the state is held and then released. Directed sequences cover kills of idle threads, a kill and a fault in the same cycle, several threads faulting at once, and out-of-range thread ids.

// File: rtl/abt_pkg.sv
package abt_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    C_NONE  = 3'd0,
    C_CCR   = 3'd1,
    C_EVT   = 3'd2,
    C_PER   = 3'd3,
    C_GO    = 3'd4,
    C_FETCH = 3'd5,
    C_UNDEF = 3'd6
  } cause_e;

  localparam logic [2:0] OP_PLAIN = 3'd0;
  localparam logic [2:0] OP_CCR   = 3'd1;
  localparam logic [2:0] OP_EVT   = 3'd2;
  localparam logic [2:0] OP_PER   = 3'd3;
  localparam logic [2:0] OP_GO    = 3'd4;
endpackage

// File: rtl/abt_classify.sv
module abt_classify
  import abt_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NEV  = 8,
  parameter int NPER = 4,
  parameter int ARGW = 3
) (
  input  logic [2:0]      op_i,
  input  logic [ARGW-1:0] arg_i,
  input  logic            ns_i,
  input  logic            sec_txn_i,
  input  logic            fetch_err_i,
  input  logic            bad_i,
  input  logic [NEV-1:0]  ev_ns_i,
  input  logic [NPER-1:0] per_ns_i,
  input  logic [NCH-1:0]  ch_ns_i,
  output cause_e          cause_o
);
  localparam int ARGN = 1 << ARGW;

  logic [ARGN-1:0] ev_pad, per_pad, ch_pad;
  logic            ev_in, per_in, ch_in;

  always_comb begin
    ev_pad  = '0;
    per_pad = '0;
    ch_pad  = '0;
    ev_pad[NEV-1:0]   = ev_ns_i;
    per_pad[NPER-1:0] = per_ns_i;
    ch_pad[NCH-1:0]   = ch_ns_i;
  end

  assign ev_in  = 32'(arg_i) < NEV;
  assign per_in = 32'(arg_i) < NPER;
  assign ch_in  = 32'(arg_i) < NCH;

  always_comb begin
    cause_o = C_NONE;
    case (op_i)
      OP_PLAIN: cause_o = C_NONE;
      OP_CCR:   if (ns_i && sec_txn_i) cause_o = C_CCR;
      OP_EVT:   if (!ev_in) cause_o = C_UNDEF;
                else if (ns_i && !ev_pad[arg_i]) cause_o = C_EVT;
      OP_PER:   if (!per_in) cause_o = C_UNDEF;
                else if (ns_i && !per_pad[arg_i]) cause_o = C_PER;
      OP_GO:    if (!ch_in) cause_o = C_UNDEF;
                else if (ns_i && !ch_pad[arg_i]) cause_o = C_GO;
      default:  cause_o = C_UNDEF;
    endcase
    if (bad_i)       cause_o = C_UNDEF;
    if (fetch_err_i) cause_o = C_FETCH;
  end

  always_comb begin
    a_r7_fetch_first: assert (!fetch_err_i || cause_o == C_FETCH);
    a_r8_bad_over_sec: assert (fetch_err_i || !bad_i || cause_o == C_UNDEF);
  end
endmodule

// File: rtl/abt_slot.sv
module abt_slot
  import abt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               kill_i,
  output logic               flt_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               flt_q, flt_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;

  always_comb begin
    flt_d   = flt_q;
    cause_d = cause_q;
    if (kill_i) begin
      flt_d   = 1'b0;
      cause_d = C_NONE;
    end
    if (set_i) begin
      flt_d   = 1'b1;
      cause_d = cause_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q   <= 1'b0;
      cause_q <= C_NONE;
    end else begin
      flt_q   <= flt_d;
      cause_q <= cause_d;
    end
  end

  assign flt_o   = flt_q;
  assign cause_o = cause_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q && !kill_i |=> flt_q && $stable(cause_q));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i && !set_i |=> !flt_q && cause_q == C_NONE);
  a_r9_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> cause_q != C_NONE);
endmodule

// File: rtl/abt_precise_detector.sv
module abt_precise_detector
  import abt_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NEV  = 8,
  parameter int NPER = 4,
  parameter int ARGW = 3,
  parameter int AW   = 32,
  localparam int NTH  = NCH + 1,
  localparam int TIDW = $clog2(NTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_vld,
  input  logic [TIDW-1:0]      ins_tid,
  input  logic [AW-1:0]        ins_pc,
  input  logic [2:0]           ins_op,
  input  logic [ARGW-1:0]      ins_arg,
  input  logic                 ins_sec_txn,
  input  logic                 ins_bad,
  input  logic                 ins_fetch_err,
  input  logic [NTH-1:0]       thr_ns,
  input  logic [NEV-1:0]       ev_ns_cfg,
  input  logic [NPER-1:0]      per_ns_cfg,
  input  logic [NCH-1:0]       ch_ns_cfg,
  input  logic                 kill_vld,
  input  logic [TIDW-1:0]      kill_tid,
  output logic                 ex_vld,
  output logic                 ex_nop,
  output logic                 pc_ld,
  output logic [TIDW-1:0]      pc_ld_tid,
  output logic [AW-1:0]        pc_ld_addr,
  output logic [NTH-1:0]       flt_vec,
  output logic [CAUSE_W*NTH-1:0] cause_bus,
  output logic                 abort_o
);
  localparam int TIDN = 1 << TIDW;

  logic [TIDN-1:0] ns_pad, flt_pad;
  logic            tid_ok, accept, fault;
  cause_e          cause;

  always_comb begin
    ns_pad  = '0;
    flt_pad = '0;
    ns_pad[NTH-1:0]  = thr_ns;
    flt_pad[NTH-1:0] = flt_vec;
  end

  assign tid_ok = 32'(ins_tid) < NTH;
  assign accept = ins_vld && tid_ok && !flt_pad[ins_tid];
  assign fault  = accept && (cause != C_NONE);

  abt_classify #(.NCH(NCH), .NEV(NEV), .NPER(NPER), .ARGW(ARGW)) u_cls (
    .op_i(ins_op), .arg_i(ins_arg), .ns_i(ns_pad[ins_tid]),
    .sec_txn_i(ins_sec_txn), .fetch_err_i(ins_fetch_err), .bad_i(ins_bad),
    .ev_ns_i(ev_ns_cfg), .per_ns_i(per_ns_cfg), .ch_ns_i(ch_ns_cfg),
    .cause_o(cause)
  );

  for (genvar t = 0; t < NTH; t++) begin : g_slot
    abt_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .set_i(fault && ins_tid == TIDW'(t)),
      .cause_i(cause),
      .kill_i(kill_vld && kill_tid == TIDW'(t)),
      .flt_o(flt_vec[t]),
      .cause_o(cause_bus[CAUSE_W*t +: CAUSE_W])
    );
  end

  logic            ex_vld_d, ex_nop_d, abort_d;
  logic [TIDW-1:0] tid_q;
  logic [AW-1:0]   addr_q;
  logic            flt_any_q;

  assign ex_vld_d = accept && !fault;
  assign ex_nop_d = fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld <= 1'b0;
      ex_nop <= 1'b0;
      pc_ld  <= 1'b0;
    end else begin
      ex_vld <= ex_vld_d;
      ex_nop <= ex_nop_d;
      pc_ld  <= fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid_q  <= '0;
      addr_q <= '0;
    end else if (fault) begin
      tid_q  <= ins_tid;
      addr_q <= ins_pc;
    end
  end

  assign pc_ld_tid  = tid_q;
  assign pc_ld_addr = addr_q;

  assign abort_d = |flt_vec;
  assign flt_any_q = abort_d;
  assign abort_o = flt_any_q;

  a_r1_rewind_addr: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> pc_ld && pc_ld_addr == $past(ins_pc) && pc_ld_tid == $past(ins_tid));
  a_r2_nop_alone: assert property (@(posedge clk) disable iff (!rst_n)
    ex_nop |-> pc_ld && !ex_vld);
  a_r7_fetch_nop: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ins_fetch_err |=> ex_nop && !ex_vld);
  a_r11_bad_tid: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && !tid_ok |=> !ex_vld && !ex_nop && !pc_ld);
  a_r10_abort_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_o) |-> $past(fault));
endmodule

// File: tb/sim_abt_precise_detector.sv
module sim_abt_precise_detector;
  localparam int NCH = 4, NEV = 8, NPER = 4, ARGW = 3, AW = 32;
  localparam int NTH = NCH + 1, TIDW = $clog2(NTH);

  logic clk = 1'b0;
  logic rst_n;
  logic ins_vld, ins_sec_txn, ins_bad, ins_fetch_err, kill_vld;
  logic [TIDW-1:0] ins_tid, kill_tid, pc_ld_tid;
  logic [AW-1:0] ins_pc, pc_ld_addr;
  logic [2:0] ins_op;
  logic [ARGW-1:0] ins_arg;
  logic [NTH-1:0] thr_ns, flt_vec;
  logic [NEV-1:0] ev_ns_cfg;
  logic [NPER-1:0] per_ns_cfg;
  logic [NCH-1:0] ch_ns_cfg;
  logic [3*NTH-1:0] cause_bus;
  logic ex_vld, ex_nop, pc_ld, abort_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  abt_precise_detector u0 (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expc(int op, int arg, bit ns, bit st, bit fe, bit bad,
                              logic [7:0] ev, logic [3:0] pe, logic [3:0] ch);
    if (fe) return 5;
    if (bad) return 6;
    case (op)
      0: return 0;
      1: return (ns && st) ? 1 : 0;
      2: begin if (arg >= NEV) return 6; return (ns && !ev[arg]) ? 2 : 0; end
      3: begin if (arg >= NPER) return 6; return (ns && !pe[arg]) ? 3 : 0; end
      4: begin if (arg >= NCH) return 6; return (ns && !ch[arg]) ? 4 : 0; end
      default: return 6;
    endcase
  endfunction

  function automatic string tag(int c);
    case (c)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic issue(input int tid, input int op, input int arg, input bit st,
                       input bit fe, input bit bad, input logic [AW-1:0] pc);
    ins_vld = 1; ins_tid = TIDW'(tid); ins_op = 3'(op); ins_arg = ARGW'(arg);
    ins_sec_txn = st; ins_fetch_err = fe; ins_bad = bad; ins_pc = pc;
    @(posedge clk); #1;
    ins_vld = 0; kill_vld = 0;
    @(negedge clk);
  endtask

  task automatic kill(input int tid);
    kill_vld = 1; kill_tid = TIDW'(tid);
    @(posedge clk); #1; kill_vld = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pc;
    rst_n = 0; ins_vld = 0; ins_tid = 0; ins_pc = 0; ins_op = 0; ins_arg = 0;
    ins_sec_txn = 0; ins_bad = 0; ins_fetch_err = 0; kill_vld = 0; kill_tid = 0;
    thr_ns = 0; ev_ns_cfg = 0; per_ns_cfg = 0; ch_ns_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset ex", {ex_vld, ex_nop, pc_ld, abort_o}, 0);
    chk("R10 reset flt", flt_vec, 0);
    chk("R10 reset cause", cause_bus, 0);

    pc = 32'h1000_0000;
    for (int cfg = 0; cfg < 2; cfg++) begin
      ev_ns_cfg  = cfg ? ~8'b1010_0110 : 8'b1010_0110;
      per_ns_cfg = cfg ? ~4'b0101 : 4'b0101;
      ch_ns_cfg  = cfg ? ~4'b0011 : 4'b0011;
      for (int tid = 0; tid < NTH; tid++)
        for (int op = 0; op < 8; op++)
          for (int arg = 0; arg < 8; arg++)
            for (int ns = 0; ns < 2; ns++)
              for (int ep = 0; ep < 3; ep++) begin
                bit fe, bad, st;
                int e;
                fe = (ep == 2); bad = (ep == 1); st = arg[0];
                thr_ns = ns ? '1 : '0;
                e = expc(op, arg, ns[0], st, fe, bad, ev_ns_cfg, per_ns_cfg, ch_ns_cfg);
                pc = pc + 4;
                issue(tid, op, arg, st, fe, bad, pc);
                if (e == 0) begin
                  chk("R2 exec", {ex_vld, ex_nop, pc_ld}, 3'b100);
                  chk("R10 no abort", abort_o, 0);
                end else begin
                  chk({tag(e), " nop"}, {ex_vld, ex_nop}, 2'b01);
                  chk({tag(e), " cause"}, cause_bus[3*tid +: 3], e);
                  chk("R1 pc", {pc_ld, pc_ld_tid, pc_ld_addr}, {1'b1, TIDW'(tid), pc});
                  chk("R10 abort", {abort_o, flt_vec}, {1'b1, NTH'(1 << tid)});
                  issue(tid, 0, 0, 0, 1, 0, pc + 32'h100);
                  chk("R9 dropped", {ex_vld, ex_nop, pc_ld}, 0);
                  chk("R9 cause held", cause_bus[3*tid +: 3], e);
                  kill(tid);
                  chk("R9 killed", {abort_o, flt_vec, cause_bus}, 0);
                end
              end
    end

    // R9 kill of an idle thread, and set winning over kill
    thr_ns = '1;
    issue(1, 0, 0, 0, 1, 0, 32'h2000);
    kill(3);
    chk("R9 idle kill", flt_vec, 5'b00010);
    kill_vld = 1; kill_tid = 2;
    issue(2, 5, 0, 0, 0, 0, 32'h2004);
    chk("R9 set wins", flt_vec, 5'b00110);
    chk("R9 set cause", cause_bus[6 +: 3], 6);
    kill_vld = 1; kill_tid = 1;
    issue(4, 4, 0, 0, 0, 0, 32'h2008);
    chk("R6 manager go", cause_bus[12 +: 3], 4);
    chk("R9 kill with other set", flt_vec, 5'b10100);
    kill(2);
    chk("R10 abort held", abort_o, 1);
    kill(4);
    chk("R10 abort clear", {abort_o, flt_vec}, 0);

    // R11 out-of-range thread ids
    for (int t = NTH; t < (1 << TIDW); t++) begin
      issue(t, 7, 0, 0, 1, 1, 32'h3000);
      chk("R11 ignored", {ex_vld, ex_nop, pc_ld, abort_o, flt_vec}, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule